// File: doc/BRIEF.md
# Seconds Counter with Alarm and Two-Level Interrupt Gating

This block is a memory-mapped real-time seconds counter. A prescaler divides the core clock down to a once-per-second tick, and a 32-bit count advances on that tick. Software can load the count at any time. A compare register raises an alarm event on the cycle the count takes the programmed value. A periodic mode can instead raise events on every second or on a faster programmable tick.

Events are recorded twice. One copy goes into a local status flag that is cleared by writing one. The other goes into a cause flag in a separate system window that is cleared by writing zero. The single level-high interrupt line follows the cause flag, gated by a mask bit held in that same system window.

Every accepted write opens a settle window of programmable length. During that window the block shows a busy flag and drops any further write.

Top module: `sec_rtc`

## Requirements
- R1: After reset, every register reads zero, and `irq` and `busy` are low.
- R2: The seconds count increases by one on every PRESCALE-th core clock after reset, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to the count (local offset 0x0C) loads the written value. If the write lands on a tick cycle, the loaded value wins and that increment is lost.
- R4: With the alarm enable (configuration bit 0) set, the count taking a new value equal to the compare register (local offset 0x10) sets status bit 0 and cause bit 0. With the enable clear, no alarm event occurs.
- R5: The status register (local offset 0x00) reports the event in bit 0 and reads 0 in bit 1. Writing a 1 to bit 0 clears the event, writing a 0 leaves it as it is, and a new event in the same cycle wins over the clear.
- R6: The system register (system window, offset 0x08) shows the cause in bit 0 and the mask bits in bits 3:2, which can be read and written. Writing 0 to bit 0 clears the cause and writing 1 leaves it unchanged; a new event in the same cycle wins.
- R7: `irq` is high exactly while cause bit 0 and mask bit 2 are both set.
- R8: With the periodic enable (configuration bit 1) and the rate select (configuration bit 2) both set, every seconds tick raises an event.
- R9: With the periodic enable set and the rate select clear, an event is raised every FAST_DIV core clocks.
- R10: A write taken while `busy` is low drives `busy` high for the next SETTLE cycles. A write requested while `busy` is high has no effect.
- R11: The configuration register (local offset 0x04) reads back bits 2:0 as written. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| winSel | input | 1 | 0 selects the local window, 1 selects the system window |
| addr | input | 5 | Byte offset within the selected window |
| wrEn | input | 1 | Write request |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `winSel`/`addr`, combinational |
| busy | output | 1 | Settle window active; writes are dropped |
| irq | output | 1 | Level-high interrupt |

## Verification
Four directed patterns are used, each separating one pair of outcomes:
- A count write timed onto a tick cycle shows whether the load wins over the increment.
- An all-ones load followed by a tick checks the wrap.
- Alarms with the enable set and then clear show whether the enable gates the event.
- Clearing the status and cause flags in turn shows that the two levels are independent.

Both periodic rates are then run, so the one-second and fast tick sources are checked separately. Finally, a seeded random mix of writes is applied, and the compare value is often placed one count ahead of the loaded time. This mix exercises the priority between event and clear, and the dropping of writes during the settle window, against a cycle-level model built from the requirements.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam logic [4:0] OFS_STATUS = 5'h00;
  localparam logic [4:0] OFS_CFG    = 5'h04;
  localparam logic [4:0] OFS_TIME   = 5'h0C;
  localparam logic [4:0] OFS_ALARM  = 5'h10;
  localparam logic [4:0] OFS_SYS    = 5'h08;

  typedef struct packed {
    logic wrStatus;
    logic wrCfg;
    logic wrTime;
    logic wrAlarm;
    logic wrSys;
    logic secTick;
    logic fastTick;
  } rtcStrb_t;
endpackage

// File: rtl/sec_rtc_ctrl.sv
module sec_rtc_ctrl
  import sec_rtc_pkg::*;
#(
  parameter int PRESCALE = 100_000_000,
  parameter int FAST_DIV = 25_000_000,
  parameter int SETTLE   = 500
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     winSel,
  input  logic [4:0] addr,
  input  logic     wrEn,
  output logic     busy,
  output rtcStrb_t strb
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;

  logic [PW-1:0] preCnt;
  logic [FW-1:0] fastCnt;
  logic secTick, fastTick, accept;

  assign secTick  = (preCnt == PW'(PRESCALE - 1));
  assign fastTick = (fastCnt == FW'(FAST_DIV - 1));
  assign accept   = wrEn && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      fastCnt <= '0;
    end else begin
      preCnt  <= secTick ? '0 : preCnt + 1'b1;
      fastCnt <= fastTick ? '0 : fastCnt + 1'b1;
    end
  end

  generate
    if (SETTLE > 0) begin : g_settle
      localparam int BW = $clog2(SETTLE + 1);
      logic [BW-1:0] busyCnt;
      always_ff @(posedge clk) begin
        if (!rstN)              busyCnt <= '0;
        else if (accept)        busyCnt <= BW'(SETTLE);
        else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      end
      assign busy = (busyCnt != '0);
    end else begin : g_nosettle
      assign busy = 1'b0;
    end
  endgenerate

  always_comb begin
    strb          = '0;
    strb.secTick  = secTick;
    strb.fastTick = fastTick;
    if (accept) begin
      if (winSel) begin
        strb.wrSys = (addr == OFS_SYS);
      end else begin
        strb.wrStatus = (addr == OFS_STATUS);
        strb.wrCfg    = (addr == OFS_CFG);
        strb.wrTime   = (addr == OFS_TIME);
        strb.wrAlarm  = (addr == OFS_ALARM);
      end
    end
  end
endmodule

// File: rtl/sec_rtc_dp.sv
module sec_rtc_dp
  import sec_rtc_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  rtcStrb_t      strb,
  input  logic          winSel,
  input  logic [4:0]    addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] rdata,
  output logic          irq,
  output logic [TW-1:0] timeQ,
  output logic          causeQ,
  output logic [1:0]    maskQ
);
  logic [TW-1:0] alarmQ, timeNext;
  logic [2:0]    cfgQ;
  logic          statusQ, timeUpd, alarmHit, perHit, evt;

  assign timeNext = strb.wrTime ? wdata : timeQ + 1'b1;
  assign timeUpd  = strb.wrTime | strb.secTick;
  assign alarmHit = timeUpd && cfgQ[0] && (timeNext == alarmQ);
  assign perHit   = cfgQ[1] && (cfgQ[2] ? strb.secTick : strb.fastTick);
  assign evt      = alarmHit | perHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeQ   <= '0;
      alarmQ  <= '0;
      cfgQ    <= '0;
      statusQ <= 1'b0;
      causeQ  <= 1'b0;
      maskQ   <= '0;
    end else begin
      if (timeUpd)      timeQ  <= timeNext;
      if (strb.wrAlarm) alarmQ <= wdata;
      if (strb.wrCfg)   cfgQ   <= wdata[2:0];
      if (strb.wrSys)   maskQ  <= wdata[3:2];
      if (evt)                              statusQ <= 1'b1;
      else if (strb.wrStatus && wdata[0])   statusQ <= 1'b0;
      if (evt)                              causeQ  <= 1'b1;
      else if (strb.wrSys && !wdata[0])     causeQ  <= 1'b0;
    end
  end

  assign irq = causeQ & maskQ[0];

  always_comb begin
    rdata = '0;
    if (winSel) begin
      if (addr == OFS_SYS) begin
        rdata[0]   = causeQ;
        rdata[3:2] = maskQ;
      end
    end else begin
      case (addr)
        OFS_STATUS: rdata[0]   = statusQ;
        OFS_CFG:    rdata[2:0] = cfgQ;
        OFS_TIME:   rdata      = timeQ;
        OFS_ALARM:  rdata      = alarmQ;
        default:    rdata      = '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int PRESCALE = 100_000_000,
  parameter int FAST_DIV = 25_000_000,
  parameter int SETTLE   = 500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        winSel,
  input  logic [4:0]  addr,
  input  logic        wrEn,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        busy,
  output logic        irq
);
  rtcStrb_t    strb;
  logic [31:0] timeQ;
  logic        causeQ;
  logic [1:0]  maskQ;

  sec_rtc_ctrl #(.PRESCALE(PRESCALE), .FAST_DIV(FAST_DIV), .SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .winSel(winSel), .addr(addr), .wrEn(wrEn),
    .busy(busy), .strb(strb)
  );

  sec_rtc_dp #(.TW(32)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .winSel(winSel), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .timeQ(timeQ),
    .causeQ(causeQ), .maskQ(maskQ)
  );
endmodule

// File: rtl/sec_rtc_chk.sv
module sec_rtc_chk
  import sec_rtc_pkg::*;
#(
  parameter int SETTLE = 500
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        busy,
  input logic        irq,
  input rtcStrb_t    strb,
  input logic [31:0] timeQ,
  input logic [31:0] wdata,
  input logic        causeQ,
  input logic [1:0]  maskQ
);
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.secTick && !strb.wrTime |=> timeQ == $past(timeQ) + 32'd1); // R2
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.secTick && !strb.wrTime |=> $stable(timeQ)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTime |=> timeQ == $past(wdata)); // R3
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    causeQ && !(strb.wrSys && !wdata[0]) |=> causeQ); // R6
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> maskQ[0] && causeQ); // R7
  generate
    if (SETTLE > 0) begin : g_busy
      AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
        wrEn && !busy |=> busy); // R10
    end
  endgenerate
endmodule

bind sec_rtc sec_rtc_chk #(.SETTLE(SETTLE)) u_chk (.*);

// File: tb/tb_sec_rtc.sv
module tb_sec_rtc;
  localparam int PRESCALE = 20;
  localparam int FAST_DIV = 4;
  localparam int SETTLE   = 3;

  logic clk = 1'b0, rstN = 1'b0, winSel = 1'b0, wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic busy, irq;
  int nChecks = 0, nFails = 0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  sec_rtc #(.PRESCALE(PRESCALE), .FAST_DIV(FAST_DIV), .SETTLE(SETTLE)) dut (
    .clk(clk), .rstN(rstN), .winSel(winSel), .addr(addr), .wrEn(wrEn),
    .wdata(wdata), .rdata(rdata), .busy(busy), .irq(irq)
  );

  // reference model built from the requirements
  int mPre, mFast, mBusy;
  logic [31:0] mTime, mAlarm;
  logic [2:0]  mCfg;
  logic        mStat, mCause;
  logic [1:0]  mMask;

  always @(posedge clk) begin
    automatic bit sT, fT, acc, upd, ev;
    automatic logic [31:0] nt;
    if (!rstN) begin
      mPre <= 0; mFast <= 0; mBusy <= 0; mTime <= '0; mAlarm <= '0;
      mCfg <= '0; mStat <= 1'b0; mCause <= 1'b0; mMask <= '0;
    end else begin
      sT  = (mPre == PRESCALE - 1);
      fT  = (mFast == FAST_DIV - 1);
      acc = wrEn && (mBusy == 0);
      mPre  <= sT ? 0 : mPre + 1;
      mFast <= fT ? 0 : mFast + 1;
      mBusy <= acc ? SETTLE : ((mBusy != 0) ? mBusy - 1 : 0);
      upd = 1'b0; nt = mTime;
      if (acc && !winSel && addr == 5'h0C) begin nt = wdata; upd = 1'b1; end
      else if (sT) begin nt = mTime + 1; upd = 1'b1; end
      mTime <= nt;
      if (acc && !winSel && addr == 5'h10) mAlarm <= wdata;
      if (acc && !winSel && addr == 5'h04) mCfg <= wdata[2:0];
      if (acc && winSel && addr == 5'h08) mMask <= wdata[3:2];
      ev = (upd && mCfg[0] && nt == mAlarm) || (mCfg[1] && (mCfg[2] ? sT : fT));
      if (ev) mStat <= 1'b1;
      else if (acc && !winSel && addr == 5'h00 && wdata[0]) mStat <= 1'b0;
      if (ev) mCause <= 1'b1;
      else if (acc && winSel && addr == 5'h08 && !wdata[0]) mCause <= 1'b0;
    end
  end

  function automatic logic [31:0] expRead(input logic w, input logic [4:0] a);
    if (w) return (a == 5'h08) ? {28'b0, mMask, 1'b0, mCause} : 32'b0;
    case (a)
      5'h00:   return {31'b0, mStat};
      5'h04:   return {29'b0, mCfg};
      5'h0C:   return mTime;
      5'h10:   return mAlarm;
      default: return 32'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    check("R7 irq", {31'b0, irq}, {31'b0, mCause & mMask[0]});
    check("R10 busy", {31'b0, busy}, {31'b0, mBusy != 0});
  end

  task automatic rd(input logic w, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); winSel = w; addr = a; #1 d = rdata;
  endtask

  task automatic rdChk(input string req, input logic w, input logic [4:0] a);
    logic [31:0] d;
    rd(w, a, d);
    check(req, d, expRead(w, a));
  endtask

  task automatic wr(input logic w, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    winSel = w; addr = a; wdata = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic waitPre(input int v);
    do @(negedge clk); while (!(mPre == v && !busy));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1; running = 1'b1;
    // R1 reset state
    rd(0, 5'h00, d); check("R1 status", d, 0);
    rd(0, 5'h04, d); check("R1 cfg", d, 0);
    rd(0, 5'h0C, d); check("R1 time", d, 0);
    rd(0, 5'h10, d); check("R1 alarm", d, 0);
    rd(1, 5'h08, d); check("R1 sys", d, 0);
    check("R1 irq/busy", {30'b0, irq, busy}, 0);
    // R10 busy window and dropped write
    wr(0, 5'h10, 32'h1234);
    check("R10 busy after write", {31'b0, busy}, 1);
    winSel = 0; addr = 5'h10; wdata = 32'h5555; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    repeat (SETTLE) @(negedge clk);
    check("R10 busy ends", {31'b0, busy}, 0);
    rd(0, 5'h10, d); check("R10 write in busy dropped", d, 32'h1234);
    // R11 readback and unmapped
    wr(0, 5'h04, 32'hFFFF_FFF8);
    rd(0, 5'h04, d); check("R11 cfg bits", d, 0);
    rd(0, 5'h08, d); check("R11 unmapped local", d, 0);
    rd(1, 5'h00, d); check("R11 unmapped sys", d, 0);
    // R3 load on a tick cycle
    waitPre(PRESCALE - 1);
    winSel = 0; addr = 5'h0C; wdata = 32'd700; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; #1;
    check("R3 load beats tick", rdata, 32'd700);
    // R2 wrap
    waitPre(2);
    wr(0, 5'h0C, 32'hFFFF_FFFF);
    rd(0, 5'h0C, d); check("R2 loaded all ones", d, 32'hFFFF_FFFF);
    waitPre(0);
    rd(0, 5'h0C, d); check("R2 wrap to zero", d, 0);
    waitPre(0);
    rd(0, 5'h0C, d); check("R2 step", d, 1);
    // R4 alarm with enable, R7 irq
    wr(1, 5'h08, 32'hD);
    wr(0, 5'h04, 32'h1);
    wr(0, 5'h10, mTime + 2);
    repeat (3 * PRESCALE) @(negedge clk);
    rd(0, 5'h00, d); check("R4 status set", d, 1);
    rd(1, 5'h08, d); check("R4 cause set", d, 32'hD);
    check("R7 irq high", {31'b0, irq}, 1);
    // R5 W1C
    wr(0, 5'h00, 32'h0);
    rd(0, 5'h00, d); check("R5 write 0 keeps", d, 1);
    wr(0, 5'h00, 32'h1);
    rd(0, 5'h00, d); check("R5 write 1 clears", d, 0);
    check("R7 irq held by cause", {31'b0, irq}, 1);
    // R6 cause clear
    wr(1, 5'h08, 32'hD);
    rd(1, 5'h08, d); check("R6 write 1 keeps cause", d, 32'hD);
    wr(1, 5'h08, 32'hC);
    rd(1, 5'h08, d); check("R6 write 0 clears cause", d, 32'hC);
    check("R7 irq low", {31'b0, irq}, 0);
    // R4 disabled alarm
    wr(0, 5'h04, 32'h0);
    wr(0, 5'h10, mTime + 1);
    repeat (2 * PRESCALE + 2) @(negedge clk);
    rd(0, 5'h00, d); check("R4 no event when disabled", d, 0);
    rd(1, 5'h08, d); check("R4 no cause when disabled", d, 32'hC);
    // R8 periodic one-second
    wr(0, 5'h04, 32'h6);
    waitPre(3);
    wr(0, 5'h00, 32'h1);
    rd(0, 5'h00, d); check("R8 cleared before tick", d, 0);
    waitPre(0);
    rd(0, 5'h00, d); check("R8 event on tick", d, 1);
    // R9 periodic fast
    wr(0, 5'h04, 32'h2);
    wr(1, 5'h08, 32'h4);
    rdChk("R9 cause after clear", 1, 5'h08);
    repeat (FAST_DIV) @(negedge clk);
    rd(1, 5'h08, d); check("R9 fast event", d, 32'h5);
    // random mix, R4 R5 R6 R10
    for (int i = 0; i < 300; i++) begin
      int sel;
      logic [31:0] v;
      sel = $urandom_range(0, 5);
      v = $urandom;
      case (sel)
        0: wr(0, 5'h00, v);
        1: wr(0, 5'h04, {29'b0, v[2:0]});
        2: wr(0, 5'h0C, v[1:0] == 0 ? mAlarm - 1 : v);
        3: wr(0, 5'h10, v[1] ? mTime + 1 : v);
        4: wr(1, 5'h08, v);
        default: begin
          winSel = v[0]; addr = {v[3:2], 3'b000}; wdata = v; wrEn = 1'b1;
          @(negedge clk); wrEn = 1'b0;
        end
      endcase
      rdChk("R5 random status", 0, 5'h00);
      rdChk("R6 random sys", 1, 5'h08);
      rdChk("R3 random time", 0, 5'h0C);
      rdChk("R11 random cfg", 0, 5'h04);
    end
    running = 1'b0;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule